// File: doc/BRIEF.md
# Single-Step Trace Exception Controller

This block sits next to a pipelined processor's program controller and produces one debug exception per executed instruction while the trace bit of the status register is set. When a traced instruction retires, the block stalls the fetch path for a fixed number of flush bubbles. It then pulses an exception-take strobe carrying the trace vector address.

The block recognises three cases that must not be traced. A repeat instruction and its repetitions form one traced unit, so only the final repetition counts. Instructions executed as a fast interrupt never trace. A long-interrupt handler runs untraced because its entry saves the status bits and clears the trace bit. The matching return restores the saved bits, so tracing resumes with the next sequential instruction.

A system-stack overflow or underflow latches a non-recoverable stack-error request. It is taken once, at vector 0x0002, and it beats a trace request due in the same cycle. The block also arbitrates a single lower-priority interrupt request against the current mask level and against trace activity.

Top module: `trace_step_ctrl`

## Requirements
- R1: After reset, stall, exc_take, trace_en, stk_pending and ext_accept are 0 and mask_lvl is 0.
- R2: A retire in a cycle where trace_en=1, rep_busy=0, fast_irq=0 and stall=0 raises stall in exactly the next three cycles. In the cycle after those three, exc_take pulses for one cycle with exc_vector=0x0004.
- R3: A retire with rep_busy=1 never starts a trace. The retire of the final repetition, with rep_busy=0, does start one.
- R4: A retire with fast_irq=1 never starts a trace.
- R5: With trace_en=0, no retire starts a trace.
- R6: hdl_enter saves {trace_en, mask_lvl} on an internal stack of four entries, clears trace_en and sets mask_lvl to 3 from the next cycle. hdl_return restores the most recently saved pair, and nesting is handled last-in first-out.
- R7: stack_fault sets stk_pending from the next cycle, and it stays set until stk_clear. The request is taken exactly once, as an exc_take pulse with exc_vector=0x0002. When no flush is running, this pulse comes in the cycle after the fault. During a flush, it is deferred to the last flush cycle or later.
- R8: A stack-error request that is live in the last flush cycle of a trace takes the exception slot with vector 0x0002. That trace request is then discarded.
- R9: ext_accept is high only when ext_req=1, ext_ipl >= mask_lvl, stall=0, no trace is starting in that cycle and no untaken stack error is live. With mask_lvl=3, only ext_ipl=3 can be accepted.
- R10: trace_wr loads trace_wdata into trace_en when neither hdl_enter nor hdl_return is active. hdl_enter takes priority over hdl_return, and hdl_return over trace_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| rep_busy | input | 1 | Retiring instruction is a repeat or a non-final repetition |
| fast_irq | input | 1 | Retiring instruction belongs to a fast interrupt |
| trace_wr | input | 1 | Software write of the trace bit |
| trace_wdata | input | 1 | Value for the trace bit |
| hdl_enter | input | 1 | Long-handler entry call executed |
| hdl_return | input | 1 | Return from interrupt executed |
| stack_fault | input | 1 | System stack overflow or underflow |
| stk_clear | input | 1 | Clears the latched stack error |
| ext_req | input | 1 | Other pending interrupt request |
| ext_ipl | input | 2 | Priority level of ext_req |
| stall | output | 1 | Flush bubble in progress |
| exc_take | output | 1 | One-cycle exception-take strobe |
| exc_vector | output | 16 | Vector address for exc_take |
| trace_en | output | 1 | Current trace bit |
| mask_lvl | output | 2 | Current interrupt mask level |
| stk_pending | output | 1 | Latched stack error |
| ext_accept | output | 1 | ext_req granted this cycle |

## Verification
The assertions assume that the processor never retires an instruction while stall is high. They also assume that hdl_enter and hdl_return are never active in the same cycle, and that the handler nesting depth never exceeds the four-entry save stack. The stimulus keeps to these rules. Retire pulses are issued only after the flush bubbles and the take pulse have passed, and entries and returns stay paired and shallow. Within those limits the sequences are varied: repeat chains, fast-interrupt retires, nested handlers and stack faults placed both in idle cycles and inside a flush. A behavioural model then predicts every output on every cycle.

// File: rtl/trace_step_ctrl.sv
module trace_step_ctrl #(
  parameter int VEC_W = 16,
  parameter int FLUSH_CYC = 3,
  parameter int SAVE_DEPTH = 4,
  parameter logic [VEC_W-1:0] TRACE_VEC = 'h4,
  parameter logic [VEC_W-1:0] STK_VEC = 'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             rep_busy,
  input  logic             fast_irq,
  input  logic             trace_wr,
  input  logic             trace_wdata,
  input  logic             hdl_enter,
  input  logic             hdl_return,
  input  logic             stack_fault,
  input  logic             stk_clear,
  input  logic             ext_req,
  input  logic [1:0]       ext_ipl,
  output logic             stall,
  output logic             exc_take,
  output logic [VEC_W-1:0] exc_vector,
  output logic             trace_en,
  output logic [1:0]       mask_lvl,
  output logic             stk_pending,
  output logic             ext_accept
);
  localparam int CW = $clog2(FLUSH_CYC + 1);
  localparam int IW = $clog2(SAVE_DEPTH);
  localparam int PW = $clog2(SAVE_DEPTH + 1);

  logic [CW-1:0]    cnt_q;
  logic             trace_q;
  logic [1:0]       mask_q;
  logic             stk_q, stk_done_q;
  logic             take_q;
  logic [VEC_W-1:0] vec_q;
  logic [2:0]       save_q [SAVE_DEPTH];
  logic [PW-1:0]    sp_q;
  logic [PW-1:0]    sp_top;

  wire trace_fire = retire && trace_q && !rep_busy && !fast_irq && (cnt_q == '0);
  wire last_flush = (cnt_q == CW'(1));
  wire stk_live   = !stk_done_q && (stk_q || stack_fault);
  wire stk_take   = stk_live && ((cnt_q == '0) || last_flush);

  assign sp_top = sp_q - PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      take_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (trace_fire)
        cnt_q <= CW'(FLUSH_CYC);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CW'(1);
      take_q <= stk_take || last_flush;
      vec_q  <= stk_take ? STK_VEC : (last_flush ? TRACE_VEC : vec_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk_q <= 1'b0;
      stk_done_q <= 1'b0;
    end else if (stk_clear) begin
      stk_q <= 1'b0;
      stk_done_q <= 1'b0;
    end else begin
      if (stack_fault) stk_q <= 1'b1;
      if (stk_take) stk_done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trace_q <= 1'b0;
      mask_q <= 2'd0;
      sp_q <= '0;
      for (int i = 0; i < SAVE_DEPTH; i++) save_q[i] <= '0;
    end else if (hdl_enter) begin
      save_q[sp_q[IW-1:0]] <= {trace_q, mask_q};
      sp_q <= sp_q + PW'(1);
      trace_q <= 1'b0;
      mask_q <= 2'd3;
    end else if (hdl_return) begin
      if (sp_q != '0) begin
        {trace_q, mask_q} <= save_q[sp_top[IW-1:0]];
        sp_q <= sp_top;
      end
    end else if (trace_wr) begin
      trace_q <= trace_wdata;
    end
  end

  assign stall       = (cnt_q != '0);
  assign exc_take    = take_q;
  assign exc_vector  = vec_q;
  assign trace_en    = trace_q;
  assign mask_lvl    = mask_q;
  assign stk_pending = stk_q;
  assign ext_accept  = ext_req && (ext_ipl >= mask_q) && !stall && !trace_fire && !stk_live;
endmodule

// File: rtl/trace_step_ctrl_chk.sv
module trace_step_ctrl_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire,
  input logic             rep_busy,
  input logic             fast_irq,
  input logic             hdl_enter,
  input logic             stk_clear,
  input logic             ext_req,
  input logic [1:0]       ext_ipl,
  input logic             stall,
  input logic             exc_take,
  input logic [VEC_W-1:0] exc_vector,
  input logic             trace_en,
  input logic [1:0]       mask_lvl,
  input logic             stk_pending,
  input logic             ext_accept
);
  assert_trace_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && trace_en && !rep_busy && !fast_irq && !stall) |=> stall);
  assert_take_after_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> exc_take);
  assert_rep_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && rep_busy && !stall) |=> !stall);
  assert_fast_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && fast_irq && !stall) |=> !stall);
  assert_off_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !trace_en && !stall) |=> !stall);
  assert_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_enter |=> (!trace_en && mask_lvl == 2'd3));
  assert_stk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_pending && !stk_clear) |=> stk_pending);
  assert_vec_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (exc_vector == VEC_W'('h2) || exc_vector == VEC_W'('h4)));
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_accept |-> (ext_req && !stall && ext_ipl >= mask_lvl));
  assert_mask3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_lvl == 2'd3 && ext_ipl != 2'd3) |-> !ext_accept);
endmodule

bind trace_step_ctrl trace_step_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire(retire), .rep_busy(rep_busy), .fast_irq(fast_irq),
  .hdl_enter(hdl_enter), .stk_clear(stk_clear), .ext_req(ext_req), .ext_ipl(ext_ipl),
  .stall(stall), .exc_take(exc_take), .exc_vector(exc_vector), .trace_en(trace_en),
  .mask_lvl(mask_lvl), .stk_pending(stk_pending), .ext_accept(ext_accept)
);

// File: tb/trace_step_ctrl_bench.sv
module trace_step_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic retire = 0, rep_busy = 0, fast_irq = 0, trace_wr = 0, trace_wdata = 0;
  logic hdl_enter = 0, hdl_return = 0, stack_fault = 0, stk_clear = 0, ext_req = 0;
  logic [1:0] ext_ipl = 0;
  logic stall, exc_take, trace_en, stk_pending, ext_accept;
  logic [15:0] exc_vector;
  logic [1:0] mask_lvl;

  trace_step_ctrl u_trace_step_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  int m_cnt = 0, m_trace = 0, m_mask = 0, m_stk = 0, m_done = 0, m_take = 0, m_vec = 0;
  int m_save[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_trace = 0; m_mask = 0; m_stk = 0; m_done = 0; m_take = 0; m_vec = 0;
      m_save.delete();
    end else begin
      bit fire, live, stake;
      fire  = retire && m_trace != 0 && !rep_busy && !fast_irq && m_cnt == 0;
      live  = m_done == 0 && (m_stk != 0 || stack_fault);
      stake = live && m_cnt <= 1;
      m_take = (stake || m_cnt == 1) ? 1 : 0;
      if (stake) m_vec = 2; else if (m_cnt == 1) m_vec = 4;
      if (fire) m_cnt = 3; else if (m_cnt > 0) m_cnt--;
      if (stk_clear) begin m_stk = 0; m_done = 0; end
      else begin
        if (stack_fault) m_stk = 1;
        if (stake) m_done = 1;
      end
      if (hdl_enter) begin
        m_save.push_back(m_trace * 4 + m_mask);
        m_trace = 0; m_mask = 3;
      end else if (hdl_return) begin
        if (m_save.size() > 0) begin
          int v;
          v = m_save.pop_back();
          m_trace = v / 4; m_mask = v % 4;
        end
      end else if (trace_wr) m_trace = trace_wdata;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      int acc;
      acc = (ext_req && ext_ipl >= m_mask && m_cnt == 0 &&
             !(retire && m_trace != 0 && !rep_busy && !fast_irq) &&
             !(m_done == 0 && (m_stk != 0 || stack_fault))) ? 1 : 0;
      check("stall", stall, m_cnt != 0);
      check("exc_take", exc_take, m_take);
      if (m_take != 0) check("exc_vector", exc_vector, m_vec);
      check("trace_en", trace_en, m_trace);
      check("mask_lvl", mask_lvl, m_mask);
      check("stk_pending", stk_pending, m_stk);
      check("ext_accept", ext_accept, acc);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk); #1;
      retire = 0; trace_wr = 0; hdl_enter = 0; hdl_return = 0; stack_fault = 0; stk_clear = 0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 20000) @(negedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1; #1;
    cur_req = "R1";
    @(negedge clk);
    check("reset stall", stall, 0); check("reset take", exc_take, 0);
    check("reset trace", trace_en, 0); check("reset mask", mask_lvl, 0);
    check("reset stk", stk_pending, 0); check("reset accept", ext_accept, 0);
    @(posedge clk); #1;

    cur_req = "R5";
    retire = 1; tick(3);

    cur_req = "R10";
    trace_wr = 1; trace_wdata = 1; tick(2);

    cur_req = "R2";
    for (int k = 0; k < 3; k++) begin retire = 1; tick(5 + k); end
    retire = 1; tick(5); retire = 1; tick(6);

    cur_req = "R3";
    rep_busy = 1;
    for (int k = 0; k < 4; k++) begin retire = 1; tick(1); end
    rep_busy = 0; retire = 1; tick(6);

    cur_req = "R4";
    fast_irq = 1;
    for (int k = 0; k < 3; k++) begin retire = 1; tick(1); end
    fast_irq = 0; tick(2);

    cur_req = "R9";
    ext_req = 1;
    for (int k = 0; k < 4; k++) begin ext_ipl = 2'(k); tick(1); end
    ext_ipl = 1; retire = 1; tick(1); tick(5);
    ext_req = 0;

    cur_req = "R6";
    hdl_enter = 1; tick(1);
    retire = 1; tick(2);
    ext_req = 1;
    for (int k = 0; k < 4; k++) begin ext_ipl = 2'(k); tick(1); end
    ext_req = 0;
    trace_wr = 1; trace_wdata = 1; tick(1);
    hdl_enter = 1; tick(1);
    hdl_return = 1; tick(1);
    retire = 1; tick(6);
    hdl_return = 1; tick(1);
    retire = 1; tick(6);

    cur_req = "R10";
    hdl_enter = 1; trace_wr = 1; trace_wdata = 1; tick(1);
    hdl_return = 1; trace_wr = 1; trace_wdata = 0; tick(1);
    trace_wr = 1; trace_wdata = 1; tick(2);

    cur_req = "R7";
    stack_fault = 1; tick(1);
    ext_req = 1; ext_ipl = 3; tick(3);
    stack_fault = 1; tick(2);
    stk_clear = 1; tick(2);
    ext_req = 0;
    retire = 1; tick(1);
    stack_fault = 1; tick(6);
    stk_clear = 1; tick(1);

    cur_req = "R8";
    retire = 1; tick(3);
    stack_fault = 1; tick(5);
    stk_clear = 1; tick(1);
    retire = 1; tick(6);

    cur_req = "R5";
    trace_wr = 1; trace_wdata = 0; tick(1);
    retire = 1; tick(4);

    summary();
  end
endmodule